// File: doc/BRIEF.md
# Word-Wide GPIO Register Block with Set and Clear Ports

This block holds the output state of a bank of general-purpose pins behind a simple memory-mapped bus. Software programs a direction word and a scratch word. It changes the pin-level word through two write-only ports: one ORs bits in and the other clears them. The level word drives the output pins continuously. Nine interrupt lines exist for system wiring: eight serve individual low pins and one is shared by the upper pins. All nine stay inactive.

A set or clear write is a guarded operation. It takes effect only when the written word overlaps at least one bit whose direction is output (direction bit = 1). When it takes effect, the whole written word is applied, including bits configured as inputs. When there is no overlap, the write is dropped and a one-cycle reject pulse is raised.

The bus accepts one full-word request per cycle, qualified by a valid strobe and a write flag. Read data is registered and appears on the cycle after the request. It holds until the next read.

Top module: `gpio_setclr_regs`

## Requirements
- R1: After reset, the level, direction and scratch words are zero, `pin_out` and `rd_data` are zero, and `reject_pulse` is low.
- R2: A write to byte offset 0x04 loads all 32 bits of the direction word, and a read of 0x04 returns it.
- R3: A write to offset 0x08 whose data shares a set bit with the direction word ORs the entire written data into the level word, including bits whose direction is input.
- R4: A write to offset 0x0C whose data shares a set bit with the direction word clears every level bit that is set in the written data.
- R5: A write to 0x08 or 0x0C whose data shares no set bit with the direction word leaves the level word unchanged. It raises `reject_pulse` for exactly one cycle, in the cycle after the request.
- R6: A write to offset 0x20 loads the full scratch word, and a read of 0x20 returns it.
- R7: Writes to 0x00, 0x10, 0x14, 0x18, to unmapped offsets, or to addresses whose two low bits are nonzero change no state and raise no reject pulse.
- R8: A read of 0x00 returns the level word. Reads of any offset other than 0x00, 0x04 and 0x20, and of misaligned addresses, return zero.
- R9: Read data appears on `rd_data` in the cycle after a read request. `pin_out` shows a level-word change in the cycle after the write that caused it.
- R10: `irq_low` and `irq_high` are low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe, one transfer per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, held between reads |
| pin_out | output | 32 | Current level word driven to the pins |
| irq_low | output | 8 | Per-pin interrupts for the low pins, always low |
| irq_high | output | 1 | Shared interrupt for the upper pins, always low |
| reject_pulse | output | 1 | One-cycle pulse after a dropped set or clear write |

## Verification
The hardest case to reach is a guarded write whose data is mostly input-direction bits. Such a write must either land in full or be refused in full, and a masked implementation gives the same answer for output bits alone. The stimulus first programs a direction word covering only the low byte. It then sends a set word and a clear word that each touch one output bit plus several input-direction bits, followed by words confined to input bits. The bench checks the full level word on `pin_out` and the reject pulse in the following cycle. Ignored offsets are written with all-ones data and then read back, so that any stray update would show up.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   localparam int unsigned OFS_LEVEL   = 32'h00;
   localparam int unsigned OFS_DIR     = 32'h04;
   localparam int unsigned OFS_SET     = 32'h08;
   localparam int unsigned OFS_CLR     = 32'h0C;
   localparam int unsigned OFS_SCRATCH = 32'h20;

   typedef enum logic [1:0] {
      RSEL_NONE,
      RSEL_LEVEL,
      RSEL_DIR,
      RSEL_SCRATCH
   } rsel_e;

   typedef struct packed {
      logic dir_we;
      logic set_we;
      logic clr_we;
      logic scr_we;
   } wstrobe_t;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output wstrobe_t          wr,
   output logic              rd,
   output rsel_e             rsel
);

   logic              aligned;
   logic [ADDR_W-1:0] word_addr;

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign aligned   = (addr[1:0] == 2'b00);
         assign word_addr = addr;
      end else begin : g_loose
         assign aligned   = 1'b1;
         assign word_addr = {addr[ADDR_W-1:2], 2'b00};
      end
   endgenerate

   logic hit_level, hit_dir, hit_set, hit_clr, hit_scr;
   assign hit_level = aligned && (word_addr == ADDR_W'(OFS_LEVEL));
   assign hit_dir   = aligned && (word_addr == ADDR_W'(OFS_DIR));
   assign hit_set   = aligned && (word_addr == ADDR_W'(OFS_SET));
   assign hit_clr   = aligned && (word_addr == ADDR_W'(OFS_CLR));
   assign hit_scr   = aligned && (word_addr == ADDR_W'(OFS_SCRATCH));

   logic do_wr;
   assign do_wr     = valid && write;
   assign rd        = valid && !write;
   assign wr.dir_we = do_wr && hit_dir;
   assign wr.set_we = do_wr && hit_set;
   assign wr.clr_we = do_wr && hit_clr;
   assign wr.scr_we = do_wr && hit_scr;

   always_comb begin
      rsel = RSEL_NONE;
      if (hit_level)    rsel = RSEL_LEVEL;
      else if (hit_dir) rsel = RSEL_DIR;
      else if (hit_scr) rsel = RSEL_SCRATCH;
   end

endmodule

// File: rtl/gpio_sc_wreg.sv
module gpio_sc_wreg #(
   parameter int unsigned    W       = 32,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= d;
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));   // R2

endmodule

// File: rtl/gpio_sc_level.sv
module gpio_sc_level #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] dir,
   output logic [W-1:0] level,
   output logic         drop
);

   logic overlap;
   assign overlap = |(dir & wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         drop  <= 1'b0;
      end else begin
         drop <= (set_we || clr_we) && !overlap;
         if (set_we && overlap)      level <= level | wdata;
         else if (clr_we && overlap) level <= level & ~wdata;
      end
   end

   AST_SET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && overlap) |=> ((level & $past(wdata)) == $past(wdata)));   // R3
   AST_CLR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && overlap) |=> ((level & $past(wdata)) == '0));             // R4
   AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_we || clr_we) && !overlap) |=> ($stable(level) && drop));     // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || clr_we) |=> ($stable(level) && !drop));                 // R7

endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
   import gpio_sc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd,
   input  rsel_e        rsel,
   input  logic [W-1:0] level,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] scratch,
   output logic [W-1:0] rdata
);

   logic [W-1:0] sel_data;

   always_comb begin
      unique case (rsel)
         RSEL_LEVEL:   sel_data = level;
         RSEL_DIR:     sel_data = dir;
         RSEL_SCRATCH: sel_data = scratch;
         default:      sel_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= sel_data;
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && rsel == RSEL_NONE) |=> (rdata == '0));        // R8
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));                              // R9

endmodule

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs
   import gpio_sc_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned N_LOW_IRQ    = 8,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    rd_data,
   output logic [DATA_W-1:0]    pin_out,
   output logic [N_LOW_IRQ-1:0] irq_low,
   output logic                 irq_high,
   output logic                 reject_pulse
);

   localparam int unsigned MIN_ADDR_W = $clog2(OFS_SCRATCH + 1);

   initial begin
      AST_ADDR_FITS: assert (ADDR_W >= MIN_ADDR_W);       // R8
      AST_IRQ_FITS:  assert (N_LOW_IRQ < DATA_W);          // R10
   end

   wstrobe_t          wr;
   logic              rd;
   rsel_e             rsel;
   logic [DATA_W-1:0] dir_q, scr_q, level_q;

   gpio_sc_decode #(
      .ADDR_W       (ADDR_W),
      .STRICT_ALIGN (STRICT_ALIGN)
   ) i_decode (
      .valid (bus_valid),
      .write (bus_write),
      .addr  (bus_addr),
      .wr    (wr),
      .rd    (rd),
      .rsel  (rsel)
   );

   gpio_sc_wreg #(.W(DATA_W)) i_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr.dir_we),
      .d     (bus_wdata),
      .q     (dir_q)
   );

   gpio_sc_wreg #(.W(DATA_W)) i_scratch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr.scr_we),
      .d     (bus_wdata),
      .q     (scr_q)
   );

   gpio_sc_level #(.W(DATA_W)) i_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr.set_we),
      .clr_we (wr.clr_we),
      .wdata  (bus_wdata),
      .dir    (dir_q),
      .level  (level_q),
      .drop   (reject_pulse)
   );

   gpio_sc_rdmux #(.W(DATA_W)) i_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (rd),
      .rsel    (rsel),
      .level   (level_q),
      .dir     (dir_q),
      .scratch (scr_q),
      .rdata   (rd_data)
   );

   assign pin_out  = level_q;
   assign irq_low  = '0;
   assign irq_high = 1'b0;

   AST_PIN_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_SET) && |(dir_q & bus_wdata))
      |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));   // R9
   AST_NO_STRAY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr.set_we || wr.clr_we) |=> !reject_pulse);              // R7

endmodule

// File: tb/test_gpio_setclr_regs.sv
module test_gpio_setclr_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data, pin_out;
   logic [7:0]  irq_low;
   logic        irq_high, reject_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_setclr_regs i_gpio_setclr_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_write    (bus_write),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .rd_data      (rd_data),
      .pin_out      (pin_out),
      .irq_low      (irq_low),
      .irq_high     (irq_high),
      .reject_pulse (reject_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at negedge; state updated at next posedge; returns at following negedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      chk(tag, rd_data, exp);   // R9: one cycle after the request
   endtask

   task automatic t_reset();
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 reject", {31'b0, reject_pulse}, 32'h0);
      rd_chk(8'h00, 32'h0, "R1 level");
      rd_chk(8'h04, 32'h0, "R1 dir");
      rd_chk(8'h20, 32'h0, "R1 scratch");
   endtask

   task automatic t_dir();
      wr(8'h04, 32'h0000_00FF);
      rd_chk(8'h04, 32'h0000_00FF, "R2 dir readback");
   endtask

   task automatic t_set();
      wr(8'h08, 32'h0000_0F01);
      chk("R3 reject low", {31'b0, reject_pulse}, 32'h0);
      chk("R9 pin_out after set", pin_out, 32'h0000_0F01);
      rd_chk(8'h00, 32'h0000_0F01, "R3 level full value");
   endtask

   task automatic t_set_drop();
      wr(8'h08, 32'h0000_F000);
      chk("R5 set reject pulse", {31'b0, reject_pulse}, 32'h1);
      chk("R5 set dropped", pin_out, 32'h0000_0F01);
      @(negedge clk);
      chk("R5 pulse one cycle", {31'b0, reject_pulse}, 32'h0);
   endtask

   task automatic t_clr();
      wr(8'h0C, 32'h0000_0301);
      chk("R4 clear applied", pin_out, 32'h0000_0C00);
      chk("R4 reject low", {31'b0, reject_pulse}, 32'h0);
   endtask

   task automatic t_clr_drop();
      wr(8'h0C, 32'h0000_0C00);
      chk("R5 clr reject pulse", {31'b0, reject_pulse}, 32'h1);
      chk("R5 clr dropped", pin_out, 32'h0000_0C00);
      @(negedge clk);
      chk("R5 clr pulse ends", {31'b0, reject_pulse}, 32'h0);
   endtask

   task automatic t_scratch();
      wr(8'h20, 32'hA5A5_5A5A);
      rd_chk(8'h20, 32'hA5A5_5A5A, "R6 scratch readback");
   endtask

   task automatic t_ignored();
      logic [7:0] addrs [7] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h24, 8'h06, 8'h09};
      foreach (addrs[i]) begin
         wr(addrs[i], 32'hFFFF_FFFF);
         chk("R7 no reject", {31'b0, reject_pulse}, 32'h0);
         chk("R7 level unchanged", pin_out, 32'h0000_0C00);
      end
      rd_chk(8'h04, 32'h0000_00FF, "R7 dir unchanged");
      rd_chk(8'h20, 32'hA5A5_5A5A, "R7 scratch unchanged");
   endtask

   task automatic t_unmapped_reads();
      logic [7:0] addrs [6] = '{8'h08, 8'h0C, 8'h10, 8'h18, 8'h40, 8'h05};
      foreach (addrs[i]) begin
         rd_chk(8'h20, 32'hA5A5_5A5A, "R8 nonzero before");
         rd_chk(addrs[i], 32'h0, "R8 unmapped zero");
      end
   endtask

   task automatic t_rd_hold();
      rd_chk(8'h04, 32'h0000_00FF, "R9 read");
      @(negedge clk);
      @(negedge clk);
      chk("R9 rd_data held", rd_data, 32'h0000_00FF);
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_low !== 8'h0 || irq_high !== 1'b0) begin
            errors++;
            $display("FAIL R10 irq actual=%h/%b expected=00/0", irq_low, irq_high);
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset_pre();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_dir();
      t_set();
      t_set_drop();
      t_clr();
      t_clr_drop();
      t_scratch();
      t_ignored();
      t_unmapped_reads();
      t_rd_hold();
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic t_reset_pre();
      chk("R1 pin_out in reset", pin_out, 32'h0);
   endtask

endmodule